// File: doc/BRIEF.md
# Multiplexed Instruction-Fetch Bus Sequencer

This block runs the external bus cycle that reads one instruction byte from off-chip program memory. One byte-wide port carries the low address byte first and the returned data later. The core hands over a 16-bit fetch address on a valid/ready request channel. The sequencer then drives the bus through a fixed cycle of whole clock periods. It returns the byte on a response strobe.

Each fetch runs in three windows. In the first, the address latch strobe is high and the low address byte is on the shared port. In the second, the strobe is low and the low byte is still driven, so an external latch can capture it. In the third, the port is released and the active-low read strobe lets memory drive data back. The high address byte stays on its own port for the whole fetch. A request is taken only when `req_valid` and `req_ready` are both high at a rising edge. `req_ready` is high when no fetch is running, and also in the last cycle of a running fetch, so the next fetch can follow with no gap. The response channel has no back-pressure. `rsp_valid` is a single-cycle pulse that the core must accept.

All state is held in edge-triggered flops with no time-outs. The clock may therefore stop at either level for any length of time.

Top module: `pfetch_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `ale`=0, `psen_n`=1, `ad_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: `req_ready` is 1 when idle and in the final cycle of a fetch, and 0 in every other cycle of a fetch. A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1.
- R3: After acceptance, `ale` is 1 for exactly 2 clock cycles, beginning in the cycle right after the accepting edge.
- R4: `ad_oe` is 1 and `ad_out` equals address bits [7:0] during both `ale` cycles and during the 1 cycle after `ale` falls. After that, `ad_oe` is 0.
- R5: `psen_n` goes to 0 exactly 1 cycle after `ale` falls and stays 0 for exactly 3 cycles.
- R6: `ad_oe` is 0 in every cycle where `psen_n` is 0.
- R7: `a_hi` equals address bits [15:8] and does not change from the first `ale` cycle to the end of the `psen_n`-low window.
- R8: `ad_in` is sampled only on the rising edge that ends the last `psen_n`-low cycle. The value on `ad_in` in earlier cycles has no effect. `rsp_valid` is 1 for exactly the next cycle, with `rsp_data` set to the sampled byte. `rsp_data` keeps that byte until the next capture.
- R9: A fetch lasts exactly 6 cycles. A request held valid during a fetch starts the next fetch in the cycle right after the previous one ends.
- R10: If the clock is stopped at either level for any length of time, every output keeps its value. The fetch then continues correctly when the clock resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing is counted in its periods |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core has a fetch address ready |
| req_ready | output | 1 | Sequencer can accept a request at this edge |
| req_addr | input | 16 | Fetch address |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds a new byte |
| rsp_data | output | 8 | Last fetched instruction byte |
| ad_out | output | 8 | Shared port output value (low address byte) |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input value (memory data) |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program read strobe, active low |

## Verification
The bound checker checks these on every cycle:
- the read strobe and the latch strobe are never active together, and the port is never driven while memory may drive it;
- the latch strobe lasts exactly two cycles and the read strobe exactly three;
- the read strobe falls one cycle after the latch strobe falls;
- the high address byte holds during the read window;
- each end of a read window brings exactly one response pulse.

Only the bench can show behaviour that needs knowledge of the values involved:
- the right address bytes appear for each request;
- only the last-cycle value of `ad_in` is captured, because the bench drives distinct values in the earlier read cycles;
- back-to-back and spaced request streams both keep the 6-cycle rhythm;
- stopping the clock high or low leaves every output frozen.

// File: rtl/pfetch_pkg.sv
package pfetch_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ADDR   = 2'd1,
    PH_HOLD   = 2'd2,
    PH_STROBE = 2'd3
  } fetch_phase_e;
endpackage

// File: rtl/pfetch_phase_ctr.sv
module pfetch_phase_ctr
  import pfetch_pkg::*;
#(
  parameter int ADDR_CYC = 2,
  parameter int HOLD_CYC = 1,
  parameter int STRB_CYC = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output logic         busy_o,
  output logic         last_o,
  output fetch_phase_e phase_o
);
  localparam int TOTAL  = ADDR_CYC + HOLD_CYC + STRB_CYC;
  localparam int CW     = $clog2(TOTAL + 1);
  localparam int HOLD_0 = ADDR_CYC;
  localparam int STRB_0 = ADDR_CYC + HOLD_CYC;

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == CW'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (last_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (!busy_q)                     phase_o = PH_IDLE;
    else if (cnt_q < CW'(HOLD_0))    phase_o = PH_ADDR;
    else if (cnt_q < CW'(STRB_0))    phase_o = PH_HOLD;
    else                             phase_o = PH_STROBE;
  end
endmodule

// File: rtl/pfetch_bus_drv.sv
module pfetch_bus_drv
  import pfetch_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] addr,
  input  fetch_phase_e  phase,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] a_hi,
  output logic          ale,
  output logic          psen_n
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)        addr_q <= '0;
    else if (start) addr_q <= addr;
  end

  assign ale    = (phase == PH_ADDR);
  assign psen_n = (phase != PH_STROBE);
  assign ad_oe  = (phase == PH_ADDR) || (phase == PH_HOLD);
  assign ad_out = ad_oe ? addr_q[DW-1:0] : '0;
  assign a_hi   = addr_q[AW-1:DW];
endmodule

// File: rtl/pfetch_capture.sv
module pfetch_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample,
  input  logic [DW-1:0] ad_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= sample;
      if (sample) rsp_data <= ad_in;
    end
  end
endmodule

// File: rtl/pfetch_seq.sv
module pfetch_seq
  import pfetch_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int ADDR_CYC = 2,
  parameter int HOLD_CYC = 1,
  parameter int STRB_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [AW-DW-1:0] a_hi,
  output logic          ale,
  output logic          psen_n
);
  logic         busy, last, start;
  fetch_phase_e phase;

  assign req_ready = !busy || last;
  assign start     = req_valid && req_ready;

  pfetch_phase_ctr #(
    .ADDR_CYC(ADDR_CYC), .HOLD_CYC(HOLD_CYC), .STRB_CYC(STRB_CYC)
  ) u_ctr (
    .clk(clk), .rst(rst), .start(start),
    .busy_o(busy), .last_o(last), .phase_o(phase)
  );

  pfetch_bus_drv #(.AW(AW), .DW(DW)) u_drv (
    .clk(clk), .rst(rst), .start(start), .addr(req_addr), .phase(phase),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .psen_n(psen_n)
  );

  pfetch_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .sample(last), .ad_in(ad_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/pfetch_seq_chk.sv
module pfetch_seq_chk #(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int ADDR_CYC = 2,
  parameter int STRB_CYC = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             rsp_valid,
  input logic             ad_oe,
  input logic [AW-DW-1:0] a_hi,
  input logic             ale,
  input logic             psen_n
);
  logic [7:0] ale_len, strb_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_len  <= '0;
      strb_len <= '0;
    end else begin
      ale_len  <= ale     ? ale_len + 1'b1  : '0;
      strb_len <= !psen_n ? strb_len + 1'b1 : '0;
    end
  end

  AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> ale_len == 8'(ADDR_CYC)); // R3
  AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |=> $fell(psen_n)); // R5
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(psen_n) |-> strb_len == 8'(STRB_CYC)); // R5
  AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
    !(ale && !psen_n)); // R5
  AST_PORT_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> !ad_oe); // R6
  AST_HI_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!psen_n && $past(!psen_n)) |-> $stable(a_hi)); // R7
  AST_RSP_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(psen_n) |-> rsp_valid); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R8
endmodule

bind pfetch_seq pfetch_seq_chk #(
  .AW(AW), .DW(DW), .ADDR_CYC(ADDR_CYC), .STRB_CYC(STRB_CYC)
) u_chk (
  .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .ad_oe(ad_oe),
  .a_hi(a_hi), .ale(ale), .psen_n(psen_n)
);

// File: tb/pfetch_seq_test.sv
`timescale 1ns/100ps
module pfetch_seq_test;
  logic        clk = 1'b0;
  logic        run = 1'b1;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  ad_in = 8'hA5;
  logic        req_ready, rsp_valid, ad_oe, ale, psen_n;
  logic [7:0]  rsp_data, ad_out, a_hi;

  int checks = 0;
  int errors = 0;
  int wd = 0;
  bit mon_on = 1'b0;

  bit          m_busy = 1'b0;
  int          m_k = 0;
  logic [15:0] m_addr = '0;
  bit          m_rsp = 1'b0;
  bit          m_have = 1'b0;
  logic [7:0]  m_data = '0;

  always begin
    #2.5;
    if (run) clk = ~clk;
  end

  pfetch_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi),
    .ale(ale), .psen_n(psen_n)
  );

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    wd++;
    if (wd > 150000) begin
      chk(1'b0, "WATCHDOG", wd, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (mon_on) begin
      bit e_ale, e_psn, e_oe, e_rdy, acc;
      e_ale = m_busy && m_k < 2;
      e_psn = !(m_busy && m_k >= 3);
      e_oe  = m_busy && m_k < 3;
      e_rdy = !m_busy || m_k == 5;
      chk(ale == e_ale, "R3 ale", ale, e_ale);
      chk(psen_n == e_psn, "R5 psen_n", psen_n, e_psn);
      chk(ad_oe == e_oe, "R4/R6 ad_oe", ad_oe, e_oe);
      chk(req_ready == e_rdy, "R2/R9 req_ready", req_ready, e_rdy);
      if (e_oe) chk(ad_out == m_addr[7:0], "R4 ad_out", ad_out, m_addr[7:0]);
      if (m_busy) chk(a_hi == m_addr[15:8], "R7 a_hi", a_hi, m_addr[15:8]);
      chk(rsp_valid == m_rsp, "R8 rsp_valid", rsp_valid, m_rsp);
      if (m_have) chk(rsp_data == m_data, "R8 rsp_data", rsp_data, m_data);
      // memory drives decoys before the last strobe cycle
      if (m_busy && m_k == 5)      ad_in = mem(m_addr);
      else if (m_busy && m_k >= 3) ad_in = ~mem(m_addr) ^ 8'(m_k);
      else                         ad_in = 8'hA5 ^ 8'(wd);
      m_rsp = m_busy && m_k == 5;
      if (m_rsp) begin
        m_data = mem(m_addr);
        m_have = 1'b1;
      end
      acc = req_valid && e_rdy;
      if (acc) begin
        m_busy = 1'b1; m_k = 0; m_addr = req_addr;
      end else if (m_busy && m_k == 5) begin
        m_busy = 1'b0; m_k = 0;
      end else if (m_busy) begin
        m_k++;
      end
    end
  end

  task automatic freeze(input bit high);
    logic [29:0] snap;
    if (high) begin
      @(posedge clk); #1;
    end else begin
      @(negedge clk); #1;
    end
    run = 1'b0;
    snap = {ale, psen_n, ad_oe, ad_out, a_hi, rsp_valid, req_ready, rsp_data[1:0]};
    #3000;
    chk(snap == {ale, psen_n, ad_oe, ad_out, a_hi, rsp_valid, req_ready, rsp_data[1:0]},
        "R10 frozen outputs",
        {ale, psen_n, ad_oe, ad_out, a_hi, rsp_valid, req_ready, rsp_data[1:0]}, snap);
    chk(clk == high, "R10 clock level held", clk, high);
    run = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ale == 1'b0, "R1 ale in reset", ale, 0);
    chk(psen_n == 1'b1, "R1 psen_n in reset", psen_n, 1);
    chk(ad_oe == 1'b0, "R1 ad_oe in reset", ad_oe, 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", rsp_valid, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    mon_on = 1'b1;
    repeat (4) @(posedge clk); #1;
    chk(req_ready == 1'b1, "R1 idle ready", req_ready, 1);
    for (int i = 0; i < 64; i++) begin
      bit got;
      req_addr  = 16'((i * 16'h2F1B) ^ (i << 9) ^ 16'h8001);
      req_valid = 1'b1;
      do begin
        @(negedge clk);
        got = req_ready;
        @(posedge clk); #1;
      end while (!got);
      if (i == 7)  freeze(1'b1);
      if (i == 20) freeze(1'b0);
      if (i % 3 != 0) begin
        req_valid = 1'b0;
        req_addr  = ~req_addr;
        repeat (6 + i % 4) @(posedge clk);
        #1;
      end
    end
    req_valid = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk); #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule